// File: doc/BRIEF.md
# Runtime column-truncated array multiplier

This block multiplies an 8-bit unsigned operand by a 9-bit unsigned operand and lets the caller trade accuracy for switching activity on every cycle. A truncation count selects how many of the least-significant partial-product columns are silenced. Each partial-product gate in the lowest KMAX columns has a third input, the enable of its own column, so a silenced column contributes nothing whatever the operands are. The adder cells fed by that column then see constant zeros and stop toggling.

The count is converted to a thermometer-coded column enable vector. Counts above KMAX saturate to KMAX. The gated partial products are reduced to two rows by a Wallace-style tree of full and half adders, and a ripple-carry adder combines the two rows into the 17-bit product. The operands and the count pass through one input register stage, so the product shows the values captured at the previous rising clock edge. A host typically holds a few allowed counts in a register and switches between them as its accuracy budget changes.

The block has no state machine: the register stage and the combinational datapath are its only structure. There are therefore no states or transitions to name.

Top module: `trunc_mult`

## Requirements
- R1: With a captured truncation count of 0, the product equals the exact unsigned product of the two captured operands.
- R2: With a captured count n (saturated to KMAX), product bits 0 to n-1 are all zero.
- R3: For any count n, the product equals the sum of 2^(i+j) over every operand bit pair with op_a[i]=1, op_b[j]=1 and i+j >= n.
- R4: A count greater than KMAX (16 by default; the count port is 5 bits wide, values 17 to 31) gives exactly the same product as a count of KMAX.
- R5: The product never exceeds the exact product of the captured operands.
- R6: The product reflects the operands and count captured at the previous rising clock edge. While rst_n is low (active low), the product is 0.
- R7: With a count of KMAX or more, where KMAX covers every column up to index 15, the product is 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the inputs are captured on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the captured inputs |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 9 | Unsigned multiplier |
| trunc_cnt | input | 5 | Number of low columns to silence; values above KMAX saturate |
| prod | output | 17 | Product, with the selected low columns truncated |

## Verification
The assertions check four properties on every cycle, against the captured operands and count:
- with a count of zero, the product matches an exact multiply;
- the column enables always form a contiguous high block whose zero count equals the saturated count;
- no product bit below the truncation point is set;
- the result never exceeds the exact product.

The exact value of a truncated product has to come from the bench's column-masked reference model, compared over sweeps of every count from 0 to 20. Those sweeps include the saturation codes, all-ones operands and zero operands. Only the bench shows the one-cycle input-to-output latency and the zero output held during reset.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef struct packed {
        logic cy;
        logic sm;
    } add_res_t;

    function automatic add_res_t full_add(input logic x, input logic y, input logic z);
        add_res_t r;
        r.sm = x ^ y ^ z;
        r.cy = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    function automatic add_res_t half_add(input logic x, input logic y);
        add_res_t r;
        r.sm = x ^ y;
        r.cy = x & y;
        return r;
    endfunction

endpackage

// File: rtl/tm_col_enable.sv
module tm_col_enable #(
    parameter int KMAX = 16,
    parameter int CW   = $clog2(KMAX + 1)
) (
    input  logic [CW-1:0]   cnt,
    output logic [KMAX-1:0] col_en
);
    logic [CW-1:0] cnt_sat;

    always_comb begin
        if (cnt > CW'(KMAX)) cnt_sat = CW'(KMAX);
        else                 cnt_sat = cnt;
    end

    for (genvar h = 0; h < KMAX; h++) begin : g_col
        assign col_en[h] = (cnt_sat <= CW'(h));
    end
endmodule

// File: rtl/tm_pp_gen.sv
module tm_pp_gen #(
    parameter int WA   = 8,
    parameter int WB   = 9,
    parameter int KMAX = 16
) (
    input  logic [WA-1:0]          a,
    input  logic [WB-1:0]          b,
    input  logic [KMAX-1:0]        col_en,
    output logic [WA-1:0][WB-1:0]  pp
);
    for (genvar i = 0; i < WA; i++) begin : g_row
        for (genvar j = 0; j < WB; j++) begin : g_bit
            if (i + j < KMAX) begin : g_gated
                assign pp[i][j] = a[i] & b[j] & col_en[i+j];
            end else begin : g_plain
                assign pp[i][j] = a[i] & b[j];
            end
        end
    end
endmodule

// File: rtl/tm_wallace.sv
module tm_wallace
    import tm_pkg::*;
#(
    parameter int WA = 8,
    parameter int WB = 9,
    localparam int NC  = WA + WB,
    localparam int MH  = 32,
    localparam int HIW = $clog2(MH),
    localparam int CIW = $clog2(NC)
) (
    input  logic [WA-1:0][WB-1:0] pp,
    output logic [NC-1:0]         row_s,
    output logic [NC-1:0]         row_c
);
    typedef logic [HIW-1:0] hix_t;
    typedef logic [CIW-1:0] cix_t;

    logic [NC-1:0][MH-1:0] cur;
    logic [NC-1:0][MH-1:0] nxt;
    int                    cnt  [NC];
    int                    ncnt [NC];
    logic                  busy;
    add_res_t              r;

    always_comb begin
        cur  = '0;
        nxt  = '0;
        busy = 1'b0;
        r    = '0;
        for (int c = 0; c < NC; c++) begin
            cnt[c]  = 0;
            ncnt[c] = 0;
        end
        for (int i = 0; i < WA; i++) begin
            for (int j = 0; j < WB; j++) begin
                cur[cix_t'(i+j)][hix_t'(cnt[i+j])] = pp[i][j];
                cnt[i+j] = cnt[i+j] + 1;
            end
        end
        for (int s = 0; s < NC; s++) begin
            busy = 1'b0;
            for (int c = 0; c < NC; c++) begin
                if (cnt[c] > 2) busy = 1'b1;
            end
            if (busy) begin
                nxt = '0;
                for (int c = 0; c < NC; c++) ncnt[c] = 0;
                for (int c = 0; c < NC; c++) begin
                    for (int k = 0; k < MH; k += 3) begin
                        if (k + 2 < cnt[c]) begin
                            r = full_add(cur[cix_t'(c)][hix_t'(k)],
                                         cur[cix_t'(c)][hix_t'(k+1)],
                                         cur[cix_t'(c)][hix_t'(k+2)]);
                        end else if (k + 1 < cnt[c]) begin
                            r = half_add(cur[cix_t'(c)][hix_t'(k)],
                                         cur[cix_t'(c)][hix_t'(k+1)]);
                        end else begin
                            r = '{cy: 1'b0, sm: cur[cix_t'(c)][hix_t'(k)]};
                        end
                        if (k < cnt[c]) begin
                            nxt[cix_t'(c)][hix_t'(ncnt[c])] = r.sm;
                            ncnt[c] = ncnt[c] + 1;
                        end
                        if ((k + 1 < cnt[c]) && (c + 1 < NC)) begin
                            nxt[cix_t'(c+1)][hix_t'(ncnt[c+1])] = r.cy;
                            ncnt[c+1] = ncnt[c+1] + 1;
                        end
                    end
                end
                cur = nxt;
                for (int c = 0; c < NC; c++) cnt[c] = ncnt[c];
            end
        end
        for (int c = 0; c < NC; c++) begin
            row_s[cix_t'(c)] = (cnt[c] > 0) ? cur[cix_t'(c)][0] : 1'b0;
            row_c[cix_t'(c)] = (cnt[c] > 1) ? cur[cix_t'(c)][1] : 1'b0;
        end
    end
endmodule

// File: rtl/tm_rca.sv
module tm_rca
    import tm_pkg::*;
#(
    parameter int W = 17
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W:0] cy;
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_cell
        add_res_t r;
        assign r         = full_add(x[k], y[k], cy[k]);
        assign sum[k]    = r.sm;
        assign cy[k+1]   = r.cy;
    end
endmodule

// File: rtl/trunc_mult.sv
module trunc_mult #(
    parameter int WA   = 8,
    parameter int WB   = 9,
    parameter int KMAX = 16,
    localparam int CW  = $clog2(KMAX + 1),
    localparam int NC  = WA + WB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WA-1:0] op_a,
    input  logic [WB-1:0] op_b,
    input  logic [CW-1:0] trunc_cnt,
    output logic [NC-1:0] prod
);
    logic [WA-1:0]         a_q;
    logic [WB-1:0]         b_q;
    logic [CW-1:0]         n_q;
    logic [KMAX-1:0]       col_en;
    logic [WA-1:0][WB-1:0] pp;
    logic [NC-1:0]         row_s;
    logic [NC-1:0]         row_c;
    logic [NC-1:0]         exact;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            n_q <= '0;
        end else begin
            a_q <= op_a;
            b_q <= op_b;
            n_q <= trunc_cnt;
        end
    end

    tm_col_enable #(.KMAX(KMAX)) u_en (.cnt(n_q), .col_en(col_en));

    tm_pp_gen #(.WA(WA), .WB(WB), .KMAX(KMAX)) u_pp (
        .a(a_q), .b(b_q), .col_en(col_en), .pp(pp)
    );

    tm_wallace #(.WA(WA), .WB(WB)) u_tree (.pp(pp), .row_s(row_s), .row_c(row_c));

    tm_rca #(.W(NC)) u_fin (.x(row_s), .y(row_c), .sum(prod));

    assign exact = NC'(a_q) * NC'(b_q);

    assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q == '0) |-> (prod == exact));

    assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prod[KMAX-1:0] & ~col_en) == '0);

    assert_thermo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~col_en & (~col_en + 1'b1)) == '0) &&
        ($countones(~col_en) == ((n_q > CW'(KMAX)) ? KMAX : int'(n_q))));

    assert_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prod <= exact);

    if (KMAX >= NC - 1) begin : g_full
        assert_all_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (n_q >= CW'(KMAX)) |-> (prod == '0));
    end
endmodule

// File: tb/test_trunc_mult.sv
module test_trunc_mult;
    localparam int WA = 8, WB = 9, KMAX = 16, CW = 5, NC = 17;

    typedef struct {
        logic [WA-1:0] a;
        logic [WB-1:0] b;
        int            n;
        logic [NC-1:0] exp;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WA-1:0] op_a = '0;
    logic [WB-1:0] op_b = '0;
    logic [CW-1:0] trunc_cnt = '0;
    logic [NC-1:0] prod;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    trunc_mult i_trunc_mult (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
                             .trunc_cnt(trunc_cnt), .prod(prod));

    function automatic logic [NC-1:0] ref_mul(logic [WA-1:0] a, logic [WB-1:0] b, int n);
        logic [NC-1:0] s = '0;
        int ns = (n > KMAX) ? KMAX : n;
        for (int i = 0; i < WA; i++)
            for (int j = 0; j < WB; j++)
                if (a[i] && b[j] && (i + j >= ns)) s = s + (NC'(1) << (i + j));
        return s;
    endfunction

    task automatic check(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(logic [WA-1:0] a, logic [WB-1:0] b, int n);
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; trunc_cnt = CW'(n);
        it.a = a; it.b = b; it.n = n; it.exp = ref_mul(a, b, n);
        q.push_back(it);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // monitor: one result per clock, sampled 1 ns after the capturing edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            logic [NC-1:0] exact, lowm;
            int ns;
            it = q.pop_front();
            ns = (it.n > KMAX) ? KMAX : it.n;
            exact = NC'(it.a) * NC'(it.b);
            lowm = ~({NC{1'b1}} << ns);
            check(it.n == 0 ? "R1 exact" : (it.n >= KMAX ? "R7/R4 full" : "R3 masked"),
                  prod, it.exp);
            if (it.n == 0) check("R1 vs multiply", prod, exact);
            check("R2 low zero", prod & lowm, '0);
            check("R5 bounded", (prod <= exact) ? 17'd1 : 17'd0, 17'd1);
            if (it.n > KMAX) check("R4 saturation", prod, ref_mul(it.a, it.b, KMAX));
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        op_a = 8'hFF; op_b = 9'h1FF;
        repeat (3) @(negedge clk);
        check("R6 reset", prod, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R6 latency: output follows only after the capturing edge
        @(negedge clk);
        op_a = 8'd3; op_b = 9'd5; trunc_cnt = '0;
        #0.5 check("R6 before edge", prod, ref_mul(8'hFF, 9'h1FF, 0));
        @(posedge clk); #1;
        check("R6 after edge", prod, 17'd15);
        for (int n = 0; n <= 20; n++) begin
            drive(8'hFF, 9'h1FF, n);
            drive(8'h00, 9'h1FF, n);
            drive(8'h01, 9'h001, n);
            drive(8'h80, 9'h100, n);
            drive(8'hAA, 9'h155, n);
            for (int k = 0; k < 30; k++) begin
                step_lfsr();
                drive(lfsr[7:0], {lfsr[15:8], lfsr[0] ^ lfsr[9]}, n);
            end
        end
        drive(8'hFF, 9'h1FF, 31);
        drive(8'h5A, 9'h0F3, 17);
        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule